// File: doc/BRIEF.md
# Bridge Configuration Register File

This block holds the configuration space of a type-1 (bridge) device in flip-flops: a 64-byte standard header plus an optional capability window for PCI Express registers. It takes one request per cycle, with a byte address, an access size of 1, 2 or 4 bytes and a write flag. Software traffic reaches it through that request port. Each bit of every dword carries a single attribute: read-only, read-write, write-one-to-clear or reserved. Reads return the selected lanes with reserved bits forced to zero. Writes are merged into the stored dword under those attributes.

Hardware next to the block can set write-one-to-clear status bits and supplies the vendor/device and revision identity. Every legal write in the active region produces a one-cycle change pulse. The pulse carries the old value, the new value and the lane mask, so local logic can react to control bits that software changes. A strap input turns the prefetchable base/limit dword read-only. A parameter decides whether the capability window exists.

Top module: `brcfg_top`

## Requirements
- R1: The dword is selected by reqAddr[7:2]. The lane is reqAddr[1:0].
  - A 1-byte read returns the byte at that lane in rspData[7:0].
  - A 2-byte read returns the 16 bits starting at that lane in rspData[15:0].
  - In both cases all higher bits are zero.
  - A 4-byte read ignores the lane.
- R2: A request whose reqSize is not 1, 2 or 4 raises rspErr with its response. It changes no register and raises no wrPulse.
- R3: Bits that are not read-only, read-write or write-one-to-clear always read as 0. A write of all ones shows this:
  - I/O base/limit dword (0x1C) reads 0x0000F0F0.
  - Expansion ROM dword (0x38) reads 0xFFFFF801.
  - Link control/status dword (0x50) reads 0x0000CFFB.
  - Dword 0x64 reads 0.
- R4: The write lane mask depends on the size:
  - size 4: 0xFFFFFFFF;
  - size 2: 0xFFFF shifted left by 8*lane;
  - size 1: 0xFF shifted left by 8*lane.
  Write data is shifted the same way. Read-write bits inside the mask take the new data. Every bit outside the mask keeps its value.
- R5: A write-one-to-clear bit inside the mask clears where the shifted write data is 1, and a 0 there has no effect. Read-only bits never change by a write. Examples:
  - Primary status (0x04 bits 31:16) holds error bits 15,14,13,12,11,8 as write-one-to-clear.
  - Its capability-list bit 4 is read-only.
  - Root status bit 16 (dword 0x60) is write-one-to-clear.
- R6: With the capability window, the active region is 0x00 to 0x7B; without it, 0x00 to 0x3F. A read outside the region returns 0 without rspErr. A write outside it changes nothing and raises no wrPulse.
- R7: Reset values are:
  - dword 0x04 = 0x00100000 (capability-list bit set);
  - dword 0x0C = 0x00010010 (header type 1, cache line 0x10);
  - dword 0x34 = 0x40 with the window, 0 without it;
  - dword 0x40 = 0x01420010 (ID 0x10, version 2, root-port type 4 in bits 7:4, slot bit 8 of the upper half).
- R8: While noPrefStrap is 1, dword 0x24 is wholly read-only and writes leave it unchanged. While the strap is 0:
  - bits 31:20 and 15:4 are read-write;
  - bits 19:16 and 3:0 are read-only.
- R9: A 1 on hwSet[g][k] sets bit 16+k of that group's status dword if that bit is write-one-to-clear. The groups are:
  - g = 0: 0x04;
  - g = 1: 0x1C;
  - g = 2: 0x3C;
  - g = 3: 0x48;
  - g = 4: 0x50;
  - g = 5: 0x58;
  - g = 6: 0x60.
  A set in the same cycle as a software clear of that bit wins.
- R10: rspValid is 1 in exactly the cycle after each request, and so is rspData for reads. rspValid is 0 after reset and after idle cycles.
- R11: A legal in-region write raises wrPulse for one cycle after the request. wrOld holds the visible dword before the write, wrNew holds the write's result and wrMask holds the lane mask.
- R12: Dword 0x00 reads idVendorDevice live. Dword 0x08 reads {16'h0604, 8'h00, idRevision}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Byte address |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, right aligned |
| noPrefStrap | input | 1 | Makes prefetchable base/limit read-only |
| idVendorDevice | input | 32 | Identity dword at 0x00 |
| idRevision | input | 8 | Revision byte at 0x08 |
| hwSet | input | 7x16 | Hardware status set, one 16-bit group per status dword |
| rspValid | output | 1 | Response valid |
| rspErr | output | 1 | Illegal access size |
| rspData | output | 32 | Read data |
| wrPulse | output | 1 | Write change pulse |
| wrOld | output | 32 | Dword value before the write |
| wrNew | output | 32 | Dword value produced by the write |
| wrMask | output | 32 | Lane mask of the write |

## Verification
Reads are tried in three ways:
- a distinct byte pattern read at every size and lane, which separates correct lane shifting and zero-extension from off-by-one-lane errors;
- all-ones writes to dwords with mixed attributes, which separate masking of reserved and read-only bits from plain storage;
- narrow writes into a wider dword, whose change pulse shows whether untouched lanes survive the merge.

Status dwords get zero and one patterns in the clear lanes, and a hardware set collides with a software clear in the same cycle. Addresses past the window, illegal sizes and the prefetchable strap show whether such accesses truly leave the state untouched.

// File: rtl/brcfg_pkg.sv
package brcfg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int HDR_DWORDS = 16;
  localparam int CAP_DWORDS = 15;
  localparam int SET_GROUPS = 7;
  localparam int IDX_W = ADDR_W - 2;
  localparam int SLOTS = 1 << IDX_W;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} size_e;

  typedef struct packed {
    logic [DATA_W-1:0] ro;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] w1c;
  } attr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              rdHit;
    logic              rdMiss;
    logic              wrHit;
    logic [IDX_W-1:0]  idx;
    size_e             sizeSel;
    logic [4:0]        shift;
    logic [DATA_W-1:0] laneMask;
  } ctl_t;

  function automatic attr_t attrOf(int idx, logic noPref);
    attr_t a;
    a = '0;
    case (idx)
      0, 2, 3, 4, 5, 16, 17, 21: a.ro = '1;
      1:  begin a.rw = 32'h0000_0147; a.ro = 32'h06B0_02B8; a.w1c = 32'hF900_0000; end
      6:  begin a.rw = 32'h00FF_FFFF; a.ro = 32'hFF00_0000; end
      7:  begin a.rw = 32'h0000_F0F0; a.ro = 32'h06A0_0F0F; a.w1c = 32'hF900_0000; end
      8:  begin a.rw = 32'hFFF0_FFF0; a.ro = 32'h000F_000F; end
      9:  begin
        if (noPref) a.ro = '1;
        else begin a.rw = 32'hFFF0_FFF0; a.ro = 32'h000F_000F; end
      end
      10, 11, 12: a.rw = '1;
      13: a.ro = 32'h0000_00FF;
      14: a.rw = 32'hFFFF_F801;
      15: begin a.rw = 32'h0B6F_00FF; a.ro = 32'h0080_FF00; a.w1c = 32'h0400_0000; end
      18: begin a.rw = 32'h0000_FFFF; a.ro = 32'h0030_0000; a.w1c = 32'h004F_0000; end
      19: a.ro = 32'hFF7F_FFFF;
      20: begin a.rw = 32'h0000_CFFB; a.ro = 32'h3FFF_0000; a.w1c = 32'hC000_0000; end
      22: begin a.rw = 32'h0000_7FFF; a.ro = 32'h00E0_0000; a.w1c = 32'h011F_0000; end
      23: begin a.rw = 32'h0000_001F; a.ro = 32'h0001_0000; end
      24: begin a.ro = 32'h0002_FFFF; a.w1c = 32'h0001_0000; end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] resetOf(int idx, bit hasCap);
    case (idx)
      1:  return 32'h0010_0000;
      3:  return 32'h0001_0010;
      13: return hasCap ? 32'h0000_0040 : 32'h0;
      16: return 32'h0142_0010;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int setGroupOf(int idx);
    case (idx)
      1: return 0;
      7: return 1;
      15: return 2;
      18: return 3;
      20: return 4;
      22: return 5;
      24: return 6;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/brcfg_ctrl.sv
module brcfg_ctrl
  import brcfg_pkg::*;
#(
  parameter int NUM_DW = HDR_DWORDS + CAP_DWORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  output ctl_t              ctl,
  output logic              rspValid,
  output logic              rspErr
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(NUM_DW);

  logic sizeOk;
  logic inRange;
  logic [1:0] lane;

  always_comb begin
    lane    = reqAddr[1:0];
    sizeOk  = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
    inRange = {1'b0, reqAddr[ADDR_W-1:2]} < LIMIT;
    ctl = '0;
    ctl.idx = reqAddr[ADDR_W-1:2];
    case (reqSize)
      3'd1: begin
        ctl.sizeSel  = SZ_BYTE;
        ctl.shift    = {lane, 3'b000};
        ctl.laneMask = 32'h0000_00FF << {lane, 3'b000};
      end
      3'd2: begin
        ctl.sizeSel  = SZ_HALF;
        ctl.shift    = {lane, 3'b000};
        ctl.laneMask = 32'h0000_FFFF << {lane, 3'b000};
      end
      default: begin
        ctl.sizeSel  = SZ_WORD;
        ctl.shift    = 5'd0;
        ctl.laneMask = '1;
      end
    endcase
    ctl.rdHit  = reqValid && !reqWrite && sizeOk && inRange;
    ctl.rdMiss = reqValid && !reqWrite && sizeOk && !inRange;
    ctl.wrHit  = reqValid && reqWrite && sizeOk && inRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !sizeOk;
    end
  end
endmodule

// File: rtl/brcfg_dp.sv
module brcfg_dp
  import brcfg_pkg::*;
#(
  parameter int NUM_DW  = HDR_DWORDS + CAP_DWORDS,
  parameter bit HAS_CAP = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctl_t                             ctl,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             noPref,
  input  logic [DATA_W-1:0]                idVendorDevice,
  input  logic [7:0]                       idRevision,
  input  logic [SET_GROUPS-1:0][15:0]      hwSet,
  output logic [DATA_W-1:0]                rspData,
  output logic                             wrPulse,
  output logic [DATA_W-1:0]                wrOld,
  output logic [DATA_W-1:0]                wrNew,
  output logic [DATA_W-1:0]                wrMask
);
  logic [DATA_W-1:0] visArr [SLOTS];
  logic [DATA_W-1:0] swArr  [SLOTS];
  logic [DATA_W-1:0] wdShift;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] rdData;

  assign wdShift = wdata << ctl.shift;

  for (genvar i = 0; i < SLOTS; i++) begin : g_dw
    if (i >= NUM_DW) begin : g_none
      assign visArr[i] = '0;
      assign swArr[i]  = '0;
    end else if (i == 0) begin : g_idDev
      assign visArr[i] = idVendorDevice;
      assign swArr[i]  = idVendorDevice;
    end else if (i == 2) begin : g_idRev
      assign visArr[i] = {16'h0604, 8'h00, idRevision};
      assign swArr[i]  = {16'h0604, 8'h00, idRevision};
    end else begin : g_reg
      localparam int G = setGroupOf(i);
      attr_t at;
      logic [DATA_W-1:0] store;
      logic [DATA_W-1:0] setBits;
      logic [DATA_W-1:0] swNew;
      logic hit;

      always_comb at = attrOf(i, noPref);

      if (G >= 0) begin : g_set
        assign setBits = {hwSet[G], 16'h0000} & at.w1c;
      end else begin : g_noSet
        assign setBits = '0;
      end

      assign hit   = ctl.wrHit && (ctl.idx == IDX_W'(i));
      assign swNew = ((store & ~(ctl.laneMask & at.rw)) | (wdShift & ctl.laneMask & at.rw))
                     & ~(wdShift & ctl.laneMask & at.w1c);

      always_ff @(posedge clk) begin
        if (!rstN) store <= resetOf(i, HAS_CAP);
        else       store <= (hit ? swNew : store) | setBits;
      end

      assign visArr[i] = store & (at.ro | at.rw | at.w1c);
      assign swArr[i]  = swNew & (at.ro | at.rw | at.w1c);
    end
  end

  always_comb begin
    rdWord  = visArr[ctl.idx];
    rdShift = rdWord >> ctl.shift;
    case (ctl.sizeSel)
      SZ_BYTE: rdData = {24'h0, rdShift[7:0]};
      SZ_HALF: rdData = {16'h0, rdShift[15:0]};
      default: rdData = rdWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      wrPulse <= 1'b0;
      wrOld   <= '0;
      wrNew   <= '0;
      wrMask  <= '0;
    end else begin
      if (ctl.rdHit)       rspData <= rdData;
      else if (ctl.rdMiss) rspData <= '0;
      wrPulse <= ctl.wrHit;
      if (ctl.wrHit) begin
        wrOld  <= visArr[ctl.idx];
        wrNew  <= swArr[ctl.idx];
        wrMask <= ctl.laneMask;
      end
    end
  end
endmodule

// File: rtl/brcfg_top.sv
module brcfg_top
  import brcfg_pkg::*;
#(
  parameter bit HAS_CAP = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [2:0]                  reqSize,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic                        noPrefStrap,
  input  logic [DATA_W-1:0]           idVendorDevice,
  input  logic [7:0]                  idRevision,
  input  logic [SET_GROUPS-1:0][15:0] hwSet,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [DATA_W-1:0]           rspData,
  output logic                        wrPulse,
  output logic [DATA_W-1:0]           wrOld,
  output logic [DATA_W-1:0]           wrNew,
  output logic [DATA_W-1:0]           wrMask
);
  localparam int NUM_DW = HAS_CAP ? (HDR_DWORDS + CAP_DWORDS) : HDR_DWORDS;

  ctl_t ctl;

  brcfg_ctrl #(.NUM_DW(NUM_DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .ctl(ctl),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  brcfg_dp #(.NUM_DW(NUM_DW), .HAS_CAP(HAS_CAP)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(reqWdata), .noPref(noPrefStrap),
    .idVendorDevice(idVendorDevice), .idRevision(idRevision), .hwSet(hwSet),
    .rspData(rspData), .wrPulse(wrPulse), .wrOld(wrOld), .wrNew(wrNew),
    .wrMask(wrMask)
  );
endmodule

// File: rtl/brcfg_chk.sv
module brcfg_chk #(
  parameter int NUM_DW = 31
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [7:0]  reqAddr,
  input logic [2:0]  reqSize,
  input logic        rspValid,
  input logic        rspErr,
  input logic [31:0] rspData,
  input logic        wrPulse,
  input logic [31:0] wrOld,
  input logic [31:0] wrNew,
  input logic [31:0] wrMask
);
  localparam logic [6:0] LIMIT = 7'(NUM_DW);

  logic sizeLegal;
  logic beyond;
  assign sizeLegal = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
  assign beyond    = {1'b0, reqAddr[7:2]} >= LIMIT;

  p_illegal_size_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !sizeLegal) |=> (rspErr && !wrPulse));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_beyond_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && sizeLegal && beyond) |=> (rspData == 32'h0 && !rspErr));

  p_beyond_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && beyond) |=> !wrPulse);

  p_byte_zero_ext_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 3'd1) |=> (rspData[31:8] == 24'h0));

  p_half_zero_ext_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 3'd2) |=> (rspData[31:16] == 16'h0));

  p_change_in_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> (((wrOld ^ wrNew) & ~wrMask) == 32'h0));

  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> $past(reqValid && reqWrite && sizeLegal && !beyond));

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrPulse && !$past(reqValid && reqWrite)) |-> 1'b0);
endmodule

bind brcfg_top brcfg_chk #(.NUM_DW(NUM_DW)) chk_i (.*);

// File: tb/brcfg_top_tb_top.sv
module brcfg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REV = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [2:0] reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic noPrefStrap = 1'b0;
  logic [31:0] idVendorDevice = 32'h1234_ABCD;
  logic [7:0] idRevision = REV;
  logic [6:0][15:0] hwSet = '0;
  logic rspValid, rspErr, wrPulse;
  logic [31:0] rspData, wrOld, wrNew, wrMask;

  int checks = 0;
  int fails = 0;
  logic [31:0] gotData, gotOld, gotNew, gotMask;
  logic gotValid, gotErr, gotPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  brcfg_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .noPrefStrap(noPrefStrap), .idVendorDevice(idVendorDevice),
    .idRevision(idRevision), .hwSet(hwSet), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .wrPulse(wrPulse), .wrOld(wrOld),
    .wrNew(wrNew), .wrMask(wrMask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    gotData = rspData; gotValid = rspValid; gotErr = rspErr; gotPulse = wrPulse;
    gotOld = wrOld; gotNew = wrNew; gotMask = wrMask;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz);
    access(1'b0, a, sz, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd);
    access(1'b1, a, sz, wd);
  endtask

  task automatic testReset();
    check("R10 rspValid after reset", {31'h0, rspValid}, 32'h0);
    check("R11 wrPulse after reset", {31'h0, wrPulse}, 32'h0);
    rd(8'h0C, 3'd4); check("R7 header/cache dword", gotData, 32'h0001_0010);
    rd(8'h04, 3'd4); check("R7 status cap bit", gotData, 32'h0010_0000);
    rd(8'h34, 3'd4); check("R7 cap pointer", gotData, 32'h0000_0040);
    rd(8'h40, 3'd4); check("R7 cap header", gotData, 32'h0142_0010);
    rd(8'h08, 3'd4); check("R12 class/revision", gotData, {16'h0604, 8'h00, REV});
    rd(8'h00, 3'd4); check("R12 identity", gotData, 32'h1234_ABCD);
    idVendorDevice = 32'h5555_0001;
    rd(8'h00, 3'd4); check("R12 identity follows input", gotData, 32'h5555_0001);
    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd(8'h00, 3'd4); check("R5 identity write ignored", gotData, 32'h5555_0001);
  endtask

  task automatic testLanes();
    wr(8'h28, 3'd4, 32'hA1B2_C3D4);
    rd(8'h28, 3'd1); check("R1 byte lane0", gotData, 32'h0000_00D4);
    rd(8'h2A, 3'd1); check("R1 byte lane2", gotData, 32'h0000_00B2);
    rd(8'h29, 3'd2); check("R1 half lane1", gotData, 32'h0000_B2C3);
    rd(8'h2B, 3'd2); check("R1 half lane3", gotData, 32'h0000_00A1);
    rd(8'h2B, 3'd4); check("R1 word ignores lane", gotData, 32'hA1B2_C3D4);
    check("R10 rspValid with read", {31'h0, gotValid}, 32'h1);
    @(negedge clk); check("R10 rspValid idle", {31'h0, rspValid}, 32'h0);
  endtask

  task automatic testMerge();
    wr(8'h18, 3'd4, 32'h1122_3344);
    rd(8'h18, 3'd4); check("R4 bus dword RO top byte", gotData, 32'h0022_3344);
    wr(8'h19, 3'd1, 32'h0000_005A);
    check("R11 pulse", {31'h0, gotPulse}, 32'h1);
    check("R11 mask byte lane1", gotMask, 32'h0000_FF00);
    check("R11 old value", gotOld, 32'h0022_3344);
    check("R11 new value", gotNew, 32'h0022_5A44);
    rd(8'h18, 3'd4); check("R4 byte merge", gotData, 32'h0022_5A44);
    wr(8'h1A, 3'd2, 32'h0000_FF77);
    check("R11 mask half lane2", gotMask, 32'hFFFF_0000);
    rd(8'h18, 3'd4); check("R4 half merge", gotData, 32'h0077_5A44);
  endtask

  task automatic testReserved();
    wr(8'h1C, 3'd4, 32'hFFFF_FFFF);
    rd(8'h1C, 3'd4); check("R3 io base/limit", gotData, 32'h0000_F0F0);
    wr(8'h38, 3'd4, 32'hFFFF_FFFF);
    rd(8'h38, 3'd4); check("R3 rom dword", gotData, 32'hFFFF_F801);
    wr(8'h50, 3'd4, 32'hFFFF_FFFF);
    rd(8'h50, 3'd4); check("R3 link ctl/sta", gotData, 32'h0000_CFFB);
    wr(8'h64, 3'd4, 32'hFFFF_FFFF);
    rd(8'h64, 3'd4); check("R3 reserved dword", gotData, 32'h0);
  endtask

  task automatic testW1c();
    @(negedge clk); hwSet[0] = 16'hFFFF;
    @(negedge clk); hwSet[0] = 16'h0000;
    rd(8'h04, 3'd4); check("R9 hw set status", gotData, 32'hF910_0000);
    wr(8'h06, 3'd2, 32'h0000_0000);
    rd(8'h04, 3'd4); check("R5 zero no clear", gotData, 32'hF910_0000);
    wr(8'h06, 3'd2, 32'h0000_0110);
    rd(8'h04, 3'd4); check("R5 clear bit8 keep RO bit4", gotData, 32'hF810_0000);
    @(negedge clk);
    hwSet[0] = 16'h8000;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h06; reqSize = 3'd2; reqWdata = 32'hFFFF;
    @(negedge clk);
    hwSet[0] = 16'h0000; reqValid = 1'b0; reqWrite = 1'b0;
    rd(8'h04, 3'd4); check("R9 set beats clear", gotData, 32'h8010_0000);
    @(negedge clk); hwSet[6] = 16'h0003;
    @(negedge clk); hwSet[6] = 16'h0000;
    rd(8'h60, 3'd4); check("R9 root status set", gotData, 32'h0001_0000);
    wr(8'h62, 3'd1, 32'h0000_0001);
    rd(8'h60, 3'd4); check("R5 root status clear", gotData, 32'h0);
  endtask

  task automatic testRegion();
    wr(8'h7C, 3'd4, 32'hFFFF_FFFF);
    check("R6 write beyond no pulse", {31'h0, gotPulse}, 32'h0);
    check("R6 write beyond no err", {31'h0, gotErr}, 32'h0);
    rd(8'h7C, 3'd4); check("R6 read beyond", gotData, 32'h0);
    rd(8'hFF, 3'd1); check("R6 read top byte", gotData, 32'h0);
    check("R6 read beyond no err", {31'h0, gotErr}, 32'h0);
  endtask

  task automatic testIllegal();
    wr(8'h28, 3'd3, 32'h0);
    check("R2 err on size 3", {31'h0, gotErr}, 32'h1);
    check("R2 no pulse", {31'h0, gotPulse}, 32'h0);
    rd(8'h28, 3'd4); check("R2 value kept", gotData, 32'hA1B2_C3D4);
    rd(8'h28, 3'd0); check("R2 err on size 0", {31'h0, gotErr}, 32'h1);
  endtask

  task automatic testStrap();
    noPrefStrap = 1'b1;
    wr(8'h24, 3'd4, 32'hFFFF_FFFF);
    rd(8'h24, 3'd4); check("R8 strap blocks write", gotData, 32'h0);
    noPrefStrap = 1'b0;
    wr(8'h24, 3'd4, 32'hFFFF_FFFF);
    rd(8'h24, 3'd4); check("R8 strap off", gotData, 32'hFFF0_FFF0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLanes();
    testMerge();
    testReserved();
    testW1c();
    testRegion();
    testIllegal();
    testStrap();
    finishRun();
  end
endmodule